// File: doc/BRIEF.md
# Debug-Port Access Scan Engine

This block is a JTAG master that turns one request into one complete access of a debug port over a four-wire test link. Each request first loads a 4-bit instruction that selects a port-register access, an access-port access, an abort or an identification read. It then walks the TAP to the data register, shifts the data register, collects what comes back on TDO, and leaves the TAP parked in Run-Test/Idle. TCK comes from the system clock through a divider that the caller sets.

For port-register and access-port accesses, the data register is 35 bits long. A 3-bit header holding the direction and two address bits goes out first, followed by 32 bits of write data. While the header is shifting, the three bits that come back form the acknowledge. The 32 bits that come back after the header are returned unchanged. Reads are posted, so these returned bits are the result of the access before this one. The caller collects a read value by issuing a later read. Some access-port accesses to data registers need the memory side to have extra time, so the engine can hold the TAP in Run-Test/Idle for a number of extra TCK cycles before it answers. An identification read shifts a bare 32-bit field with no header. Retries, bank selection and error recovery belong to the caller.

Top module: `jdp_scan_engine`

## Requirements
- R1: While reset is high, `req_ready` and `rsp_valid` are low, TCK is low and TMS is high. After reset, the engine issues 5 TCK cycles with TMS high and then 1 cycle with TMS low, which brings the TAP to Run-Test/Idle from any state. Only after that does it raise `req_ready`.
- R2: Every request loads the instruction register with a 4-bit code, shifted least significant bit first. The code depends on `req_op`: 0 selects port access (4'b1010), 1 selects access-port access (4'b1011), 2 selects abort (4'b1000) and 3 selects identification (4'b1110). The instruction phase always takes 10 TCK cycles.
- R3: For ops 0, 1 and 2, the data register is 35 bits, shifted LSB first. Bit 0 is `req_rnw` (1 = read), bits 2:1 are `req_addr`, and bits 34:3 are `req_wdata`. The data phase takes 3 + 35 + 2 TCK cycles.
- R4: For ops 0, 1 and 2, the first 3 bits captured on TDO appear on `rsp_ack`, with the first captured bit in bit 0. The next 32 captured bits appear on `rsp_data`, so a read returns the value posted by the previous access.
- R5: On `rsp_valid`, exactly one of `rsp_ok` (ack 3'b010), `rsp_wait` (ack 3'b001) or `rsp_invalid` (any other ack value) is high.
- R6: An identification read shifts only 32 bits with no header, and its data phase takes 37 TCK cycles. `rsp_data` holds the captured word, and `rsp_ack` reads 3'b010 with `rsp_ok` high.
- R7: After an access-port access with `req_addr` = 3, or with `req_bank_data` high, the engine adds `req_idle` TCK cycles with TMS low before it responds. A value of 0 adds none, and other ops never add any.
- R8: Every request ends with the TAP in Run-Test/Idle. Whenever `req_ready` is high, TCK and TMS are both low.
- R9: TMS and TDI change only when TCK falls, or while TCK is low before its first rise. TDO is sampled on the rising TCK edge.
- R10: Each half period of TCK lasts `clk_div` + 1 system clocks.
- R11: Each accepted request gives exactly one single-cycle `rsp_valid` pulse, and `req_ready` stays low from acceptance until that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | DIV_W | TCK half period minus one, in system clocks |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle; a request is taken on valid and ready |
| req_op | input | 2 | 0 port, 1 access port, 2 abort, 3 identification |
| req_addr | input | 2 | Register address bits 3:2 |
| req_rnw | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 32 | Write data payload |
| req_bank_data | input | 1 | Access-port bank points at the banked data registers |
| req_idle | input | IDLE_W | Extra Run-Test/Idle TCK cycles after a data access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ack | output | 3 | Captured acknowledge |
| rsp_data | output | 32 | Captured 32-bit word |
| rsp_ok | output | 1 | Acknowledge is OK/FAULT |
| rsp_wait | output | 1 | Acknowledge is WAIT |
| rsp_invalid | output | 1 | Acknowledge is neither |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |

## Verification
The hardest situation to reach from the ports is a read whose data comes back one access late while the extra idle window is also active. Covering it needs a target that really defers its reads, together with access-port requests that mix address 3, the bank flag and nonzero idle counts. The bench models the target's TAP controller and a posted-read port inside the bench. It chains reads so that each response must carry the value of the previous read. It counts TCK rises per request to separate idle cycles that were inserted from idle cycles that were left out, and it repeats the whole sweep at three divider settings. The target's acknowledge is forced to WAIT and to invalid codes to show that the engine reports the raw code, and that a write the target discards does not alter the register.

// File: rtl/jdp_pkg.sv
package jdp_pkg;

    localparam int HDR_W      = 3;
    localparam int PAY_W      = 32;
    localparam int ACC_LEN    = HDR_W + PAY_W;
    localparam int ID_LEN     = 32;
    localparam int IR_W       = 4;
    localparam int RST_TMS_HI = 5;

    localparam logic [2:0] ACK_OKF  = 3'b010;
    localparam logic [2:0] ACK_WAIT = 3'b001;

    typedef enum logic [1:0] {
        OP_DP    = 2'd0,
        OP_AP    = 2'd1,
        OP_ABORT = 2'd2,
        OP_ID    = 2'd3
    } op_e;

    // Each phase is one contiguous run of TCK cycles with a fixed TMS pattern
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_RST,
        PH_IRH,
        PH_IRS,
        PH_IRT,
        PH_DRH,
        PH_DRS,
        PH_DRT,
        PH_RTI
    } phase_e;

    typedef struct packed {
        logic tms;
        logic tdi;
    } pins_t;

    typedef struct packed {
        logic ok;
        logic busy;
        logic bad;
    } ackcls_t;

    typedef struct packed {
        logic [2:0]       ack;
        logic [PAY_W-1:0] data;
        ackcls_t          cls;
    } rsp_t;

    function automatic logic [IR_W-1:0] ir_code(op_e op);
        case (op)
            OP_DP:    return 4'b1010;
            OP_AP:    return 4'b1011;
            OP_ABORT: return 4'b1000;
            default:  return 4'b1110;
        endcase
    endfunction

    function automatic ackcls_t classify(logic [2:0] a);
        ackcls_t c;
        c.ok   = (a == ACK_OKF);
        c.busy = (a == ACK_WAIT);
        c.bad  = !(c.ok || c.busy);
        return c;
    endfunction

    function automatic int unsigned dr_len(op_e op);
        return (op == OP_ID) ? ID_LEN : ACC_LEN;
    endfunction

    // Last count index of a phase (phases count from zero)
    function automatic int unsigned term_of(phase_e ph, int unsigned len,
                                            int unsigned idle);
        case (ph)
            PH_RST:  return RST_TMS_HI;
            PH_IRH:  return 3;
            PH_IRS:  return IR_W - 1;
            PH_IRT:  return 1;
            PH_DRH:  return 2;
            PH_DRS:  return len - 1;
            PH_DRT:  return 1;
            PH_RTI:  return (idle == 0) ? 0 : idle - 1;
            default: return 0;
        endcase
    endfunction

    // Pin levels for one TCK cycle of a phase
    function automatic pins_t drive(phase_e ph, logic first, logic [1:0] low,
                                    logic last, logic [IR_W-1:0] ir, logic sbit);
        pins_t p;
        p.tms = 1'b0;
        p.tdi = 1'b0;
        case (ph)
            PH_RST: p.tms = !last;
            PH_IRH: p.tms = !low[1];
            PH_IRS: begin
                p.tms = last;
                p.tdi = ir[low];
            end
            PH_IRT: p.tms = first;
            PH_DRH: p.tms = first;
            PH_DRS: begin
                p.tms = last;
                p.tdi = sbit;
            end
            PH_DRT: p.tms = first;
            default: p.tms = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/jdp_tck_gen.sv
module jdp_tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tck,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             term;

    assign term = (cnt_q == div);
    assign rise = run && term && !tck;
    assign fall = run && term && tck;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            tck   <= 1'b0;
        end else if (term) begin
            cnt_q <= '0;
            tck   <= !tck;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/jdp_shift_path.sv
module jdp_shift_path
    import jdp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ACC_LEN-1:0] load_val,
    input  logic               shift_en,
    input  logic               tdo,
    input  logic               finish,
    input  logic               is_id,
    output logic               sbit,
    output logic               rsp_valid,
    output logic [2:0]         rsp_ack,
    output logic [PAY_W-1:0]   rsp_data,
    output logic               rsp_ok,
    output logic               rsp_wait,
    output logic               rsp_invalid
);
    logic [ACC_LEN-1:0] sreg_q;
    rsp_t               rsp_n, rsp_q;
    logic               vld_q;

    assign sbit = sreg_q[0];

    // Captured bits enter at the top; after N shifts they fill the top N bits
    always_ff @(posedge clk) begin
        if (rst)
            sreg_q <= '0;
        else if (load)
            sreg_q <= load_val;
        else if (shift_en)
            sreg_q <= {tdo, sreg_q[ACC_LEN-1:1]};
    end

    always_comb begin
        rsp_n.ack  = is_id ? ACK_OKF : sreg_q[HDR_W-1:0];
        rsp_n.data = sreg_q[ACC_LEN-1:HDR_W];
        rsp_n.cls  = classify(rsp_n.ack);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            rsp_q <= '0;
        end else begin
            vld_q <= finish;
            if (finish)
                rsp_q <= rsp_n;
        end
    end

    assign rsp_valid   = vld_q;
    assign rsp_ack     = rsp_q.ack;
    assign rsp_data    = rsp_q.data;
    assign rsp_ok      = rsp_q.cls.ok;
    assign rsp_wait    = rsp_q.cls.busy;
    assign rsp_invalid = rsp_q.cls.bad;
endmodule

// File: rtl/jdp_scan_seq.sv
module jdp_scan_seq
    import jdp_pkg::*;
#(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              fall,
    input  logic              req_valid,
    input  op_e               req_op,
    input  logic [1:0]        req_addr,
    input  logic              req_bank_data,
    input  logic [IDLE_W-1:0] req_idle,
    input  logic              sbit,
    output logic              req_ready,
    output logic              run,
    output logic              start,
    output logic              shift_en,
    output logic              finish,
    output logic              is_id,
    output logic              tms,
    output logic              tdi
);
    localparam int CNT_W = (IDLE_W > 6) ? IDLE_W : 6;

    phase_e            ph_q, ph_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    op_e               op_q;
    logic [IDLE_W-1:0] idle_q;
    logic              extra_q;
    logic              extra_n;
    pins_t             pins_q, pins_n;
    logic              at_end;
    int unsigned       len_w, idle_w;

    assign len_w  = dr_len(op_q);
    assign idle_w = int'(idle_q);

    always_comb begin
        at_end = (cnt_q == CNT_W'(term_of(ph_q, len_w, idle_w)));
        ph_n   = ph_q;
        cnt_n  = cnt_q + 1'b1;
        if (at_end) begin
            cnt_n = '0;
            case (ph_q)
                PH_IRH:  ph_n = PH_IRS;
                PH_IRS:  ph_n = PH_IRT;
                PH_IRT:  ph_n = PH_DRH;
                PH_DRH:  ph_n = PH_DRS;
                PH_DRS:  ph_n = PH_DRT;
                PH_DRT:  ph_n = extra_q ? PH_RTI : PH_IDLE;
                default: ph_n = PH_IDLE;
            endcase
        end
        pins_n = drive(ph_n, cnt_n == '0, cnt_n[1:0],
                       cnt_n == CNT_W'(term_of(ph_n, len_w, idle_w)),
                       ir_code(op_q), sbit);
    end

    assign extra_n   = (req_op == OP_AP) && ((req_addr == 2'b11) || req_bank_data)
                       && (req_idle != '0);
    assign req_ready = (ph_q == PH_IDLE);
    assign run       = (ph_q != PH_IDLE);
    assign start     = req_ready && req_valid;
    assign shift_en  = rise && (ph_q == PH_DRS);
    assign finish    = fall && at_end &&
                       (((ph_q == PH_DRT) && !extra_q) || (ph_q == PH_RTI));
    assign is_id     = (op_q == OP_ID);
    assign tms       = pins_q.tms;
    assign tdi       = pins_q.tdi;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q    <= PH_RST;
            cnt_q   <= '0;
            op_q    <= OP_DP;
            idle_q  <= '0;
            extra_q <= 1'b0;
            pins_q  <= pins_t'{tms: 1'b1, tdi: 1'b0};
        end else if (start) begin
            ph_q    <= PH_IRH;
            cnt_q   <= '0;
            op_q    <= req_op;
            idle_q  <= req_idle;
            extra_q <= extra_n;
            pins_q  <= pins_t'{tms: 1'b1, tdi: 1'b0};
        end else if (fall) begin
            ph_q    <= ph_n;
            cnt_q   <= cnt_n;
            pins_q  <= pins_n;
        end
    end
endmodule

// File: rtl/jdp_scan_engine.sv
module jdp_scan_engine
    import jdp_pkg::*;
#(
    parameter int DIV_W  = 8,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [1:0]        req_addr,
    input  logic              req_rnw,
    input  logic [31:0]       req_wdata,
    input  logic              req_bank_data,
    input  logic [IDLE_W-1:0] req_idle,
    output logic              rsp_valid,
    output logic [2:0]        rsp_ack,
    output logic [31:0]       rsp_data,
    output logic              rsp_ok,
    output logic              rsp_wait,
    output logic              rsp_invalid,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo
);
    op_e                op_in;
    logic               run, rise, fall, start, shift_en, finish, is_id, sbit;
    logic [ACC_LEN-1:0] load_val;

    assign op_in    = op_e'(req_op);
    assign load_val = (op_in == OP_ID) ? '0 : {req_wdata, req_addr, req_rnw};

    jdp_tck_gen #(.DIV_W(DIV_W)) u_tck (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .div  (clk_div),
        .tck  (tck),
        .rise (rise),
        .fall (fall)
    );

    jdp_scan_seq #(.IDLE_W(IDLE_W)) u_seq (
        .clk           (clk),
        .rst           (rst),
        .rise          (rise),
        .fall          (fall),
        .req_valid     (req_valid),
        .req_op        (op_in),
        .req_addr      (req_addr),
        .req_bank_data (req_bank_data),
        .req_idle      (req_idle),
        .sbit          (sbit),
        .req_ready     (req_ready),
        .run           (run),
        .start         (start),
        .shift_en      (shift_en),
        .finish        (finish),
        .is_id         (is_id),
        .tms           (tms),
        .tdi           (tdi)
    );

    jdp_shift_path u_path (
        .clk         (clk),
        .rst         (rst),
        .load        (start),
        .load_val    (load_val),
        .shift_en    (shift_en),
        .tdo         (tdo),
        .finish      (finish),
        .is_id       (is_id),
        .sbit        (sbit),
        .rsp_valid   (rsp_valid),
        .rsp_ack     (rsp_ack),
        .rsp_data    (rsp_data),
        .rsp_ok      (rsp_ok),
        .rsp_wait    (rsp_wait),
        .rsp_invalid (rsp_invalid)
    );
endmodule

// File: rtl/jdp_scan_checker.sv
module jdp_scan_checker (
    input logic clk,
    input logic rst,
    input logic tck,
    input logic tms,
    input logic tdi,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic rsp_ok,
    input logic rsp_wait,
    input logic rsp_invalid
);
    AST_PINS_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        tck |-> ($stable(tms) && $stable(tdi))); // R9

    AST_PARKED_LOW: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!tck && !tms)); // R8

    AST_ONE_ACK_CLASS: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> ($countones({rsp_ok, rsp_wait, rsp_invalid}) == 1)); // R5

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R11

    AST_BUSY_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R11

    AST_RSP_WHEN_PARKED: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> req_ready); // R8
endmodule

bind jdp_scan_engine jdp_scan_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .tck         (tck),
    .tms         (tms),
    .tdi         (tdi),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ok      (rsp_ok),
    .rsp_wait    (rsp_wait),
    .rsp_invalid (rsp_invalid)
);

// File: tb/tb_jdp_scan_engine.sv
module tb_jdp_scan_engine;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_W  = 4;
    localparam int IDLE_W = 4;
    localparam logic [31:0] IDVAL = 32'h4BA0_0477;

    // TAP states
    localparam int S_TLR = 0, S_RTI = 1, S_SELDR = 2, S_CAPDR = 3, S_SHDR = 4,
                   S_EX1DR = 5, S_PAUDR = 6, S_EX2DR = 7, S_UPDR = 8,
                   S_SELIR = 9, S_CAPIR = 10, S_SHIR = 11, S_EX1IR = 12,
                   S_PAUIR = 13, S_EX2IR = 14, S_UPIR = 15;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [DIV_W-1:0]  clk_div = 4'd1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_op = 2'd0;
    logic [1:0]        req_addr = 2'd0;
    logic              req_rnw = 1'b0;
    logic [31:0]       req_wdata = 32'd0;
    logic              req_bank_data = 1'b0;
    logic [IDLE_W-1:0] req_idle = '0;
    logic              rsp_valid;
    logic [2:0]        rsp_ack;
    logic [31:0]       rsp_data;
    logic              rsp_ok, rsp_wait, rsp_invalid;
    logic              tck, tms, tdi;
    logic              tdo = 1'b0;

    jdp_scan_engine #(.DIV_W(DIV_W), .IDLE_W(IDLE_W)) dut (
        .clk(clk), .rst(rst), .clk_div(clk_div),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_rnw(req_rnw), .req_wdata(req_wdata),
        .req_bank_data(req_bank_data), .req_idle(req_idle),
        .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_data(rsp_data),
        .rsp_ok(rsp_ok), .rsp_wait(rsp_wait), .rsp_invalid(rsp_invalid),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;

    // ---------------- target model: TAP plus posted-read port ----------------
    int          tap_st = S_SHDR;
    logic [3:0]  ir = 4'b1110;
    logic [3:0]  ir_sh = 4'd0;
    logic [34:0] dr = '0;
    logic [31:0] dp_r [4];
    logic [31:0] ap_r [4];
    logic [31:0] posted = 32'd0;
    logic [2:0]  mdl_ack = 3'b010;
    logic [31:0] abort_val = 32'd0;
    int          rises = 0;
    int          tms_hi = 0;
    time         last_rise = 0, prev_rise = 0;

    initial begin
        for (int i = 0; i < 4; i++) begin
            dp_r[i] = 32'd0;
            ap_r[i] = 32'hC000_0000 + i;
        end
    end

    function automatic int nxt(int s, logic m);
        case (s)
            S_TLR:   return m ? S_TLR   : S_RTI;
            S_RTI:   return m ? S_SELDR : S_RTI;
            S_SELDR: return m ? S_SELIR : S_CAPDR;
            S_CAPDR: return m ? S_EX1DR : S_SHDR;
            S_SHDR:  return m ? S_EX1DR : S_SHDR;
            S_EX1DR: return m ? S_UPDR  : S_PAUDR;
            S_PAUDR: return m ? S_EX2DR : S_PAUDR;
            S_EX2DR: return m ? S_UPDR  : S_SHDR;
            S_UPDR:  return m ? S_SELDR : S_RTI;
            S_SELIR: return m ? S_TLR   : S_CAPIR;
            S_CAPIR: return m ? S_EX1IR : S_SHIR;
            S_SHIR:  return m ? S_EX1IR : S_SHIR;
            S_EX1IR: return m ? S_UPIR  : S_PAUIR;
            S_PAUIR: return m ? S_EX2IR : S_PAUIR;
            S_EX2IR: return m ? S_UPIR  : S_SHIR;
            default: return m ? S_SELDR : S_RTI;
        endcase
    endfunction

    always @(posedge tck) begin
        rises++;
        if (tms) tms_hi++;
        prev_rise = last_rise;
        last_rise = $time;
        case (tap_st)
            S_TLR:   ir = 4'b1110;
            S_CAPIR: ir_sh = 4'b0001;
            S_SHIR:  ir_sh = {tdi, ir_sh[3:1]};
            S_UPIR:  ir = ir_sh;
            S_CAPDR: begin
                if (ir == 4'b1010 || ir == 4'b1011) dr = {posted, mdl_ack};
                else if (ir == 4'b1110)             dr = {3'b000, IDVAL};
                else                                dr = '0;
            end
            S_SHDR: begin
                if (ir == 4'b1110) begin
                    dr = dr >> 1;
                    dr[31] = tdi;
                end else begin
                    dr = dr >> 1;
                    dr[34] = tdi;
                end
            end
            S_UPDR: begin
                if ((ir == 4'b1010 || ir == 4'b1011) && mdl_ack == 3'b010) begin
                    if (dr[0]) posted = (ir == 4'b1011) ? ap_r[dr[2:1]] : dp_r[dr[2:1]];
                    else if (ir == 4'b1011) ap_r[dr[2:1]] = dr[34:3];
                    else dp_r[dr[2:1]] = dr[34:3];
                end else if (ir == 4'b1000) begin
                    abort_val = dr[34:3];
                end
            end
            default: ;
        endcase
        tap_st = nxt(tap_st, tms);
    end

    always @(negedge tck) begin
        if (tap_st == S_SHDR)      tdo = dr[0];
        else if (tap_st == S_SHIR) tdo = ir_sh[0];
        else                       tdo = 1'b0;
    end

    // ---------------- pin and handshake monitors ----------------
    logic pv_tck = 1'b0, pv_tms = 1'b1, pv_tdi = 1'b0;
    int   pin_glitch = 0;
    int   rsp_pulses = 0;
    int   busy_ready = 0;
    logic in_req = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (tck && pv_tck && (tms != pv_tms || tdi != pv_tdi)) pin_glitch++;
            if (rsp_valid) rsp_pulses++;
            if (in_req && req_ready && !rsp_valid) busy_ready++;
        end
        pv_tck = tck;
        pv_tms = tms;
        pv_tdi = tdi;
    end

    task automatic chk(input bit cond, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    int requests = 0;
    logic [2:0]  g_ack;
    logic [31:0] g_data;
    logic        g_ok, g_wait, g_bad;
    int          g_rises;

    task automatic do_req(input logic [1:0] op, input logic [1:0] a, input logic rnw,
                          input logic [31:0] wd, input logic bank,
                          input logic [IDLE_W-1:0] idl);
        int exp_r;
        @(negedge clk);
        req_op = op; req_addr = a; req_rnw = rnw; req_wdata = wd;
        req_bank_data = bank; req_idle = idl; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        rises = 0;
        @(negedge clk);
        req_valid = 1'b0;
        in_req = 1'b1;
        while (!rsp_valid) @(negedge clk);
        in_req = 1'b0;
        requests++;
        g_ack = rsp_ack; g_data = rsp_data;
        g_ok = rsp_ok; g_wait = rsp_wait; g_bad = rsp_invalid;
        g_rises = rises;
        exp_r = 10 + 5 + ((op == 2'd3) ? 32 : 35)
              + (((op == 2'd1) && (a == 2'd3 || bank)) ? int'(idl) : 0);
        chk(g_rises == exp_r, "R7 tck count", g_rises, exp_r);
        chk(tap_st == S_RTI && !tck && !tms, "R8 parked in run-test/idle",
            tap_st, S_RTI);
    endtask

    function automatic logic [31:0] wv(int a, int d, int sp);
        return 32'h1357_9BDF ^ (a * 32'h0101_0101) ^ (d << 20) ^ (sp << 28);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(!req_ready && !rsp_valid && !tck && tms, "R1 reset outputs",
            {req_ready, rsp_valid, tck, tms}, 4'b0001);
        rises = 0;
        tms_hi = 0;
        rst = 1'b0;
        while (!req_ready) @(negedge clk);
        chk(rises == 6, "R1 reset tck count", rises, 6);
        chk(tms_hi == 5, "R1 tms high count", tms_hi, 5);
        chk(tap_st == S_RTI, "R1 tap in run-test/idle", tap_st, S_RTI);

        for (int d = 0; d < 3; d++) begin
            clk_div = DIV_W'(d);
            // identification read
            do_req(2'd3, 2'd0, 1'b1, 32'hFFFF_FFFF, 1'b0, '0);
            chk(g_data == IDVAL, "R6 id word", g_data, IDVAL);
            chk(g_ack == 3'b010 && g_ok && !g_wait && !g_bad, "R6 id ack", g_ack, 3'b010);
            chk(ir == 4'b1110, "R2 id code", ir, 4'b1110);
            chk((last_rise - prev_rise) == time'(2 * (d + 1) * CLK_PERIOD),
                "R10 tck period", 32'(last_rise - prev_rise), 2 * (d + 1) * CLK_PERIOD);
            // port writes land at the header address
            for (int a = 0; a < 4; a++) begin
                do_req(2'd0, 2'(a), 1'b0, wv(a, d, 0), 1'b0, 4'd7);
                chk(dp_r[a] == wv(a, d, 0), "R3 write placement", dp_r[a], wv(a, d, 0));
                chk(g_ok, "R5 ok on write", g_ack, 3'b010);
            end
            chk(ir == 4'b1010, "R2 port code", ir, 4'b1010);
            // chained reads: each response holds the previous read
            do_req(2'd0, 2'd0, 1'b1, 32'd0, 1'b0, '0);
            for (int a = 1; a <= 4; a++) begin
                do_req(2'd0, 2'(a % 4), 1'b1, 32'd0, 1'b0, '0);
                chk(g_data == wv(a - 1, d, 0), "R4 posted read data", g_data,
                    wv(a - 1, d, 0));
                chk(g_ack == 3'b010, "R4 ack field", g_ack, 3'b010);
            end
            // access-port sweep over address, bank flag and idle count
            for (int a = 0; a < 4; a++) begin
                for (int b = 0; b < 2; b++) begin
                    for (int k = 0; k < 3; k++) begin
                        do_req(2'd1, 2'(a), 1'b0, wv(a, d, b * 3 + k), 1'(b),
                               IDLE_W'(k * 3));
                    end
                    chk(ap_r[a] == wv(a, d, b * 3 + 2), "R3 ap write",
                        ap_r[a], wv(a, d, b * 3 + 2));
                end
            end
            chk(ir == 4'b1011, "R2 ap code", ir, 4'b1011);
            do_req(2'd1, 2'd2, 1'b1, 32'd0, 1'b0, '0);
            do_req(2'd1, 2'd3, 1'b1, 32'd0, 1'b1, 4'd15);
            chk(g_data == wv(2, d, 5), "R4 ap posted read", g_data, wv(2, d, 5));
            // no extra idle for other ops
            do_req(2'd0, 2'd3, 1'b1, 32'd0, 1'b1, 4'd9);
            do_req(2'd2, 2'd0, 1'b0, 32'd1, 1'b1, 4'd9);
            chk(abort_val == 32'd1, "R3 abort payload", abort_val, 32'd1);
            chk(ir == 4'b1000, "R2 abort code", ir, 4'b1000);
            chk(g_ack == 3'b000 && g_bad, "R5 abort ack invalid", g_ack, 3'b000);
            do_req(2'd3, 2'd3, 1'b0, 32'd0, 1'b1, 4'd9);
        end

        // WAIT: reported raw, write discarded by the target
        mdl_ack = 3'b001;
        do_req(2'd0, 2'd1, 1'b0, 32'hDEAD_0001, 1'b0, '0);
        chk(g_ack == 3'b001 && g_wait && !g_ok && !g_bad, "R5 wait class", g_ack, 3'b001);
        mdl_ack = 3'b010;
        do_req(2'd0, 2'd1, 1'b1, 32'd0, 1'b0, '0);
        do_req(2'd0, 2'd0, 1'b1, 32'd0, 1'b0, '0);
        chk(g_data == wv(1, 2, 0), "R5 wait write had no effect", g_data, wv(1, 2, 0));
        for (int c = 0; c < 8; c++) begin
            if (c == 3'b010 || c == 3'b001) continue;
            mdl_ack = 3'(c);
            do_req(2'd0, 2'd0, 1'b1, 32'd0, 1'b0, '0);
            chk(g_ack == 3'(c) && g_bad && !g_ok && !g_wait, "R5 invalid class",
                g_ack, 3'(c));
        end
        mdl_ack = 3'b010;

        @(negedge clk);
        chk(pin_glitch == 0, "R9 pins change only on falling tck", pin_glitch, 0);
        chk(rsp_pulses == requests, "R11 one response per request", rsp_pulses, requests);
        chk(busy_ready == 0, "R11 ready low while busy", busy_ready, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog R11 actual=hung expected=response");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule